// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. A byte is first placed in a one-entry holding register. When the frame sequencer is free, it moves that byte into its shift register and sends a start bit, then the data bits with the least significant bit first, then an optional parity bit, then one, one and a half or two stop bits. While one byte is being sent, the host can load the next one. The following frame then starts with no idle gap.

The framing is set by an eight-bit mode word, which is sampled at the start of each frame. This word selects the clock factor, the character length, whether parity is sent and which parity sense is used, and the number of stop bits. Every bit period is a whole number of transmit-clock cycles: 1, 16 or 64. A break input forces the line low for as long as it is held. The frame keeps running underneath the break. A ready flag tells the host when the holding register can take another byte.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `txd_o` is 1 and `rdy_o` is 1. A reset during a frame ends that frame.
- R2: A frame is one start bit at 0, then the data bits with the least significant bit first, then the parity bit if parity is enabled, then the stop bits at 1. When no frame is being sent, `txd_o` is 1.
- R3: Mode bits [1:0] select the bit period: 01 gives 1 clock, 10 gives 16 clocks and 11 gives 64 clocks. The value 00 is handled as 01.
- R4: Mode bits [3:2] select the character length: 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. Data bits above the selected length are not sent.
- R5: Mode bit 4 enables the parity bit. When parity is enabled, mode bit 5 set to 1 makes the total count of ones in the data bits and the parity bit even. Mode bit 5 set to 0 makes that count odd.
- R6: Mode bits [7:6] select the stop time. 01 gives one bit period. 10 gives 24 clocks at the 16 factor, 96 clocks at the 64 factor and 2 clocks at the 1 factor. 11 gives two bit periods. 00 is handled as 01.
- R7: A write strobe stores `data_i` and makes `rdy_o` 0 after that edge. If the sequencer is idle, the start bit begins one edge later and `rdy_o` returns to 1 at that same edge. A byte that is waiting when the stop time ends starts its frame at once, with no idle cycle between frames.
- R8: The mode word is sampled only when a frame starts. A change to `mode_i` during a frame has no effect on that frame. The next frame uses the mode word present when that frame starts.
- R9: While `brk_i` is 1, `txd_o` is 0. The frame timing continues underneath the break, so when `brk_i` returns to 0 the line shows the frame bit due at that moment.
- R10: A write at the same edge at which a waiting byte is moved into the shift register stores the new byte, and `rdy_o` stays 0. The moved byte is sent first and the new byte follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 8 | Framing mode word |
| data_i | input | 8 | Byte to transmit |
| wr_i | input | 1 | Write strobe that loads `data_i` into the holding register |
| brk_i | input | 1 | Break command; forces the line low |
| txd_o | output | 1 | Serial output line |
| rdy_o | output | 1 | High when the holding register can accept a byte |

## Verification
Two events can fall in the same cycle: a host write, and the sequencer taking the waiting byte, either when it is idle or at the last cycle of a stop time. The bench keeps the write strobe high for two edges in a row, so the second byte arrives at the edge where the first byte is taken. It then checks that `rdy_o` stays low, that both frames come out in order, and that the bit timing of each is exact. Back-to-back frames are compared cycle by cycle against a waveform that the bench builds from the mode word. This means that an error in the stop length shows up as a shifted start bit in the second frame.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned CNT_W  = 7;
    localparam int unsigned REM_W  = 4;

    typedef enum logic [1:0] {
        BAUD_SYNC = 2'b00,
        BAUD_X1   = 2'b01,
        BAUD_X16  = 2'b10,
        BAUD_X64  = 2'b11
    } baud_e;

    typedef enum logic [1:0] {
        STOP_BAD  = 2'b00,
        STOP_ONE  = 2'b01,
        STOP_ONEH = 2'b10,
        STOP_TWO  = 2'b11
    } stop_e;

    typedef struct packed {
        stop_e      stop;
        logic       even;
        logic       par_en;
        logic [1:0] clen;
        baud_e      baud;
    } mode_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_DATA,
        SQ_PARITY,
        SQ_STOP
    } seq_e;

    function automatic logic [CNT_W-1:0] bit_len_m1(baud_e b);
        case (b)
            BAUD_X16: return CNT_W'(15);
            BAUD_X64: return CNT_W'(63);
            default:  return CNT_W'(0);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] stop_len_m1(stop_e s, baud_e b);
        case (b)
            BAUD_X16: begin
                case (s)
                    STOP_ONEH: return CNT_W'(23);
                    STOP_TWO:  return CNT_W'(31);
                    default:   return CNT_W'(15);
                endcase
            end
            BAUD_X64: begin
                case (s)
                    STOP_ONEH: return CNT_W'(95);
                    STOP_TWO:  return CNT_W'(127);
                    default:   return CNT_W'(63);
                endcase
            end
            default: begin
                if (s == STOP_ONEH || s == STOP_TWO) return CNT_W'(1);
                return CNT_W'(0);
            end
        endcase
    endfunction

    function automatic logic [REM_W-1:0] last_bit_idx(logic [1:0] clen);
        return REM_W'(4) + REM_W'(clen);
    endfunction

    function automatic logic [DATA_W-1:0] mask_data(logic [DATA_W-1:0] d, logic [1:0] clen);
        logic [DATA_W-1:0] m;
        m = {DATA_W{1'b1}} >> (2'd3 - clen);
        return d & m;
    endfunction

    function automatic logic parity_of(logic [DATA_W-1:0] d, logic even);
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/sft_hold_reg.sv
module sft_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] din_i,
    input  logic         take_i,
    output logic         full_o,
    output logic [W-1:0] dout_o
);
    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_i) begin
                data_q <= din_i;
                full_q <= 1'b1;
            end else if (take_i) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full_o = full_q;
    assign dout_o = data_q;
endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] len_m1_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_m1_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sft_frame_seq.sv
module sft_frame_seq
    import sft_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pending_i,
    input  logic [DATA_W-1:0]        hold_data_i,
    input  mode_t                    mode_i,
    input  logic                     done_i,
    output logic                     take_o,
    output logic                     load_o,
    output logic [CNT_W-1:0]         len_m1_o,
    output logic                     line_o,
    output logic                     busy_o
);
    seq_e              state_q;
    mode_t             mode_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic [REM_W-1:0]  rem_q;
    logic              line_q;
    logic              to_stop;
    logic [DATA_W-1:0] fresh;

    assign to_stop = (state_q == SQ_PARITY) ||
                     (state_q == SQ_DATA && rem_q == '0 && !mode_q.par_en);
    assign fresh   = mask_data(hold_data_i, mode_i.clen);

    always_comb begin
        take_o   = 1'b0;
        load_o   = 1'b0;
        len_m1_o = '0;
        case (state_q)
            SQ_IDLE: begin
                if (pending_i) begin
                    take_o   = 1'b1;
                    load_o   = 1'b1;
                    len_m1_o = bit_len_m1(mode_i.baud);
                end
            end
            SQ_START, SQ_DATA, SQ_PARITY: begin
                if (done_i) begin
                    load_o   = 1'b1;
                    len_m1_o = to_stop ? stop_len_m1(mode_q.stop, mode_q.baud)
                                       : bit_len_m1(mode_q.baud);
                end
            end
            SQ_STOP: begin
                if (done_i && pending_i) begin
                    take_o   = 1'b1;
                    load_o   = 1'b1;
                    len_m1_o = bit_len_m1(mode_i.baud);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            mode_q  <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            rem_q   <= '0;
            line_q  <= 1'b1;
        end else if (take_o) begin
            state_q <= SQ_START;
            mode_q  <= mode_i;
            shreg_q <= fresh;
            par_q   <= parity_of(fresh, mode_i.even);
            line_q  <= 1'b0;
        end else begin
            case (state_q)
                SQ_START: begin
                    if (done_i) begin
                        state_q <= SQ_DATA;
                        line_q  <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                        rem_q   <= last_bit_idx(mode_q.clen);
                    end
                end
                SQ_DATA: begin
                    if (done_i) begin
                        if (rem_q != '0) begin
                            line_q  <= shreg_q[0];
                            shreg_q <= shreg_q >> 1;
                            rem_q   <= rem_q - 1'b1;
                        end else if (mode_q.par_en) begin
                            state_q <= SQ_PARITY;
                            line_q  <= par_q;
                        end else begin
                            state_q <= SQ_STOP;
                            line_q  <= 1'b1;
                        end
                    end
                end
                SQ_PARITY: begin
                    if (done_i) begin
                        state_q <= SQ_STOP;
                        line_q  <= 1'b1;
                    end
                end
                SQ_STOP: begin
                    if (done_i) begin
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign line_o = line_q;
    assign busy_o = (state_q != SQ_IDLE);
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] mode_i,
    input  logic [7:0] data_i,
    input  logic       wr_i,
    input  logic       brk_i,
    output logic       txd_o,
    output logic       rdy_o
);
    logic              full_w;
    logic [DATA_W-1:0] hold_w;
    logic              take_w;
    logic              load_w;
    logic [CNT_W-1:0]  len_w;
    logic              done_w;
    logic              line_w;
    logic              busy_w;
    mode_t             mode_w;

    assign mode_w = mode_t'(mode_i);

    sft_hold_reg #(.W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr_i),
        .din_i  (data_i),
        .take_i (take_w),
        .full_o (full_w),
        .dout_o (hold_w)
    );

    sft_bit_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_w),
        .len_m1_i (len_w),
        .done_o   (done_w)
    );

    sft_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .pending_i   (full_w),
        .hold_data_i (hold_w),
        .mode_i      (mode_w),
        .done_i      (done_w),
        .take_o      (take_w),
        .load_o      (load_w),
        .len_m1_o    (len_w),
        .line_o      (line_w),
        .busy_o      (busy_w)
    );

    assign txd_o = brk_i ? 1'b0 : line_w;
    assign rdy_o = ~full_w;
endmodule

// File: rtl/sft_tx_checker.sv
module sft_tx_checker (
    input logic clk,
    input logic rst,
    input logic wr_i,
    input logic brk_i,
    input logic txd_o,
    input logic rdy_o,
    input logic xfer,
    input logic busy
);
    a_r9_break_low: assert property (@(posedge clk) disable iff (rst)
        brk_i |-> !txd_o);

    a_r2_idle_mark: assert property (@(posedge clk) disable iff (rst)
        (!busy && !brk_i) |-> txd_o);

    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        xfer |=> !txd_o);

    a_r7_xfer_needs_byte: assert property (@(posedge clk) disable iff (rst)
        xfer |-> !rdy_o);

    a_r7_write_busy: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> !rdy_o);

    a_r7_xfer_frees: assert property (@(posedge clk) disable iff (rst)
        (xfer && !wr_i) |=> rdy_o);
endmodule

bind serial_frame_tx sft_tx_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (wr_i),
    .brk_i (brk_i),
    .txd_o (txd_o),
    .rdy_o (rdy_o),
    .xfer  (take_w),
    .busy  (busy_w)
);

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mode_i = 8'h4D;
    logic [7:0] data_i = 8'h00;
    logic       wr_i = 1'b0;
    logic       brk_i = 1'b0;
    logic       txd_o;
    logic       rdy_o;

    int n_run = 0;
    int n_fail = 0;
    logic exp_q [0:2047];
    int n_exp = 0;

    always #2 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_i),
        .data_i (data_i),
        .wr_i   (wr_i),
        .brk_i  (brk_i),
        .txd_o  (txd_o),
        .rdy_o  (rdy_o)
    );

    // {mode first frame, mode second frame, byte A, byte B}
    localparam logic [31:0] VEC [8] = '{
        32'h4D_4D_A5_3C,
        32'hFD_FD_81_7E,
        32'h9A_9A_D3_2A,
        32'hB3_B3_1F_E6,
        32'h85_85_2D_12,
        32'h1C_1C_55_00,
        32'h4D_FE_96_69,
        32'h76_76_FF_C0
    };

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input logic v, input int len);
        for (int i = 0; i < len; i++) begin
            exp_q[n_exp] = v;
            n_exp++;
        end
    endtask

    // Expected waveform built from the mode decoding in R3, R4, R5, R6
    task automatic add_frame(input logic [7:0] m, input logic [7:0] d);
        int f;
        int nb;
        int sl;
        logic p;
        case (m[1:0])
            2'b10:   f = 16;
            2'b11:   f = 64;
            default: f = 1;
        endcase
        nb = 5 + int'(m[3:2]);
        case (m[7:6])
            2'b10:   sl = (f == 1) ? 2 : (f * 3) / 2;
            2'b11:   sl = 2 * f;
            default: sl = f;
        endcase
        push(1'b0, f);
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            push(d[i], f);
            p = p ^ d[i];
        end
        if (m[4]) push(m[5] ? p : ~p, f);
        push(1'b1, sl);
    endtask

    task automatic run_frames(input logic [7:0] m, input logic [7:0] m2,
                              input logic [7:0] a, input logic [7:0] b,
                              input logic ov, input int bf, input int bt);
        int na;
        int bad_a;
        int bad_b;
        int fa;
        int fb;
        logic e;
        n_exp = 0;
        add_frame(m, a);
        na = n_exp;
        add_frame(m2, b);
        bad_a = 0; bad_b = 0; fa = -1; fb = -1;
        @(negedge clk);
        mode_i = m; data_i = a; wr_i = 1'b1;
        @(negedge clk);
        if (ov) data_i = b;
        else wr_i = 1'b0;
        for (int k = 0; k < n_exp; k++) begin
            @(negedge clk);
            e = (k > bf && k <= bt) ? 1'b0 : exp_q[k];
            if (txd_o !== e) begin
                if (k < na) begin bad_a++; if (fa < 0) fa = k; end
                else begin bad_b++; if (fb < 0) fb = k; end
            end
            if (k == 0) begin
                if (ov) begin
                    check(rdy_o === 1'b0, "R10 ready held low on write during transfer", int'(rdy_o), 0);
                    wr_i = 1'b0;
                end else begin
                    check(rdy_o === 1'b1, "R7 ready after transfer", int'(rdy_o), 1);
                    data_i = b; wr_i = 1'b1;
                end
            end
            if (k == 1 && !ov) begin
                check(rdy_o === 1'b0, "R7 ready low after write", int'(rdy_o), 0);
                wr_i = 1'b0;
            end
            if (k == 2) mode_i = m2;
            if (k == bf) brk_i = 1'b1;
            if (k == bt) brk_i = 1'b0;
        end
        check(bad_a == 0, "R2 R3 R4 R5 R6 R9 first frame mismatches (first at cycle)", fa, -1);
        check(bad_b == 0, "R7 R8 R10 second frame mismatches (first at cycle)", fb, -1);
        @(negedge clk);
        check(txd_o === 1'b1, "R2 idle line high", int'(txd_o), 1);
        check(rdy_o === 1'b1, "R7 ready when idle", int'(rdy_o), 1);
    endtask

    initial begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(txd_o === 1'b1, "R1 line high in reset", int'(txd_o), 1);
        check(rdy_o === 1'b1, "R1 ready high in reset", int'(rdy_o), 1);
        rst = 1'b0;
        @(negedge clk);
        check(txd_o === 1'b1, "R1 line high after reset", int'(txd_o), 1);
        check(rdy_o === 1'b1, "R1 ready high after reset", int'(rdy_o), 1);

        for (int v = 0; v < 8; v++) begin
            run_frames(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0, -1, -1);
        end

        // R10: second write coincides with the transfer of the first byte
        run_frames(8'h9A, 8'h9A, 8'h3B, 8'hC4, 1'b1, -1, -1);
        run_frames(8'hFD, 8'hFD, 8'h5A, 8'hA5, 1'b1, -1, -1);

        // R9: break in the middle of a frame, timing continues underneath
        run_frames(8'h5E, 8'h5E, 8'h0F, 8'hF0, 1'b0, 20, 60);

        // R9: break while idle
        @(negedge clk);
        brk_i = 1'b1;
        @(negedge clk);
        check(txd_o === 1'b0, "R9 break low while idle", int'(txd_o), 0);
        brk_i = 1'b0;
        @(negedge clk);
        check(txd_o === 1'b1, "R9 line high after break", int'(txd_o), 1);

        // R1: reset during a frame
        mode_i = 8'h4E; data_i = 8'h00; wr_i = 1'b1;
        @(negedge clk);
        data_i = 8'h11;
        @(negedge clk);
        wr_i = 1'b0;
        repeat (5) @(negedge clk);
        check(txd_o === 1'b0, "R1 frame in progress before reset", int'(txd_o), 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(txd_o === 1'b1, "R1 reset ends frame", int'(txd_o), 1);
        check(rdy_o === 1'b1, "R1 reset empties holding", int'(rdy_o), 1);
        repeat (40) @(negedge clk);
        check(txd_o === 1'b1, "R1 no frame after reset", int'(txd_o), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule